// File: doc/BRIEF.md
# Scaling-Free Pipelined Circular Rotator

This block turns an angle into its cosine and sine by rotating the unit vector through a fixed chain of seven micro-rotations. One micro-rotation happens in each pipeline stage. Each micro-rotation uses a third-order Taylor form of sine and cosine built only from shifts and adds. Because that form keeps the vector length close to one, no gain correction is applied at the output.

Each stage works out its own shift index from the angle that is still left to rotate. If that residue is at least 0.25 rad, the stage takes the largest elementary step, 0.25 rad, which is shift 2. Otherwise the stage takes the step given by the highest set bit of the residue and clears that bit. A new angle may enter on every clock. A valid flag moves through the pipeline with the data, and the pipeline has no stall.

Top module: `scf_cordic_rotator`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` is 0 after that edge. The reset is synchronous and active low.
- R2: `out_valid` at any cycle equals `in_valid` from seven rising edges earlier. The block accepts an input on every cycle, and bubbles keep their positions in the stream.
- R3: `in_angle` is unsigned radians with its LSB weighing 2^-16 rad. The allowed range is 0 to 51472 (π/4). `out_cos` and `out_sin` are signed two's complement with 14 fraction bits, so 16384 is 1.0. The vector starts at (16384, 0).
- R4: Each stage chooses a shift index s from its residue r. If r ≥ 16384, then s = 2 and the next residue is r − 16384. Otherwise, if r ≠ 0, let p be the index of the highest set bit of r; then s = 16 − p and bit p is cleared.
- R5: For s ≠ 0, a stage computes x' = x − (x>>>(2s+1)) − (y>>>s) + (y>>>(3s+3)) and y' = y − (y>>>(2s+1)) + (x>>>s) − (x>>>(3s+3)). Here >>> is an arithmetic right shift on 16-bit values, so each term truncates toward minus infinity.
- R6: A stage whose residue is 0 passes its coordinates through unchanged. Angle 0 gives (16384, 0).
- R7: Angle 16384 gives (15872, 4064). Angle 8192 gives (16256, 2044).
- R8: The number of stages is fixed at seven. Angle 49152 uses three largest steps and gives (11966, 11191). Any residue left after the seventh stage is dropped.
- R9: For every angle in range, each output is within 328 LSB of the true cosine or sine times 16384.
- R10: Every valid output has cosine in 1..16384 and sine in 0..16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input angle valid |
| in_angle | input | 16 | Angle, unsigned, LSB = 2^-16 rad |
| out_valid | output | 1 | Output valid |
| out_cos | output | 16 | Cosine, signed Q1.14 |
| out_sin | output | 16 | Sine, signed Q1.14 |

## Verification
The sweep covers the angle range at a fine stride, with bubbles, and compares every output bit-for-bit against an arithmetic model of the shift rule and update equations, and against the true trigonometric values.

The corner cases aim at specific faults:
- A zero residue: a design that rotated anyway would let the cosine decay.
- Residues just below and above 16384: a wrong threshold would pick a small step where the large one belongs, which shows up as a gross angle error.
- Exactly three largest steps: a truncation fault in the shifted terms would move the low bits away from the exact literals.
- Long runs of set bits that exceed seven stages: these show whether the pipeline counts stages correctly.
- Changes in `in_valid` from cycle to cycle: a pipeline of the wrong depth would misplace the valid flags.

// File: rtl/scf_cordic_rotator.sv
module scf_cordic_rotator #(
  parameter int W      = 16,
  parameter int AW     = 16,
  parameter int STAGES = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [AW-1:0]       in_angle,
  output logic                out_valid,
  output logic signed [W-1:0] out_cos,
  output logic signed [W-1:0] out_sin
);
  localparam int FRAC = W - 2;
  localparam int SW   = $clog2(AW + 1);
  localparam logic signed [W-1:0] ONE = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
  localparam logic [AW-1:0] BIG = {2'b01, {(AW-2){1'b0}}};
  localparam logic [SW-1:0] BASIC = SW'(2);

  logic [STAGES:0]     v;
  logic signed [W-1:0] xs [STAGES+1];
  logic signed [W-1:0] ys [STAGES+1];
  logic [AW-1:0]       rs [STAGES+1];

  assign v[0]  = in_valid;
  assign xs[0] = ONE;
  assign ys[0] = '0;
  assign rs[0] = in_angle;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [SW-1:0]       sh;
    logic [AW-1:0]       r_nx;
    logic signed [W-1:0] x_nx, y_nx;
    logic [7:0]          s1, s2, s3;

    always_comb begin
      int p;
      p = 0;
      for (int i = 0; i < AW; i++)
        if (rs[g][i]) p = i;
      if (rs[g] >= BIG) begin
        sh   = BASIC;
        r_nx = rs[g] - BIG;
      end else if (rs[g] != '0) begin
        sh   = SW'(AW - p);
        r_nx = rs[g];
        r_nx[p] = 1'b0;
      end else begin
        sh   = '0;
        r_nx = '0;
      end
    end

    assign s1 = 8'(sh);
    assign s2 = 8'(2 * sh + 1);
    assign s3 = 8'(3 * sh + 3);

    always_comb begin
      if (sh == '0) begin
        x_nx = xs[g];
        y_nx = ys[g];
      end else begin
        x_nx = xs[g] - (xs[g] >>> s2) - (ys[g] >>> s1) + (ys[g] >>> s3);
        y_nx = ys[g] - (ys[g] >>> s2) + (xs[g] >>> s1) - (xs[g] >>> s3);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) v[g+1] <= 1'b0;
      else        v[g+1] <= v[g];
      xs[g+1] <= x_nx;
      ys[g+1] <= y_nx;
      rs[g+1] <= r_nx;
    end
  end

  assign out_valid = v[STAGES];
  assign out_cos   = xs[STAGES];
  assign out_sin   = ys[STAGES];
endmodule

// File: rtl/scf_cordic_rotator_chk.sv
module scf_cordic_rotator_chk #(
  parameter int W      = 16,
  parameter int AW     = 16,
  parameter int STAGES = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [AW-1:0]       in_angle,
  input logic                out_valid,
  input logic signed [W-1:0] out_cos,
  input logic signed [W-1:0] out_sin
);
  localparam logic signed [W-1:0] ONE = {2'b01, {(W-2){1'b0}}};

  logic [STAGES-1:0] vsh, zsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vsh <= '0;
      zsh <= '0;
    end else begin
      vsh <= {vsh[STAGES-2:0], in_valid};
      zsh <= {zsh[STAGES-2:0], in_valid && (in_angle == '0)};
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsh[STAGES-1]);

  // R6
  zero_angle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zsh[STAGES-1]) |-> (out_cos == ONE && out_sin == '0));

  // R10
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cos > 0 && out_cos <= ONE && out_sin >= 0 && out_sin <= ONE));
endmodule

bind scf_cordic_rotator scf_cordic_rotator_chk #(.W(W), .AW(AW), .STAGES(STAGES)) u_chk (.*);

// File: tb/scf_cordic_rotator_test.sv
module scf_cordic_rotator_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_angle = '0;
  logic out_valid;
  logic signed [15:0] out_cos, out_sin;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic        sl_v [8];
  logic [15:0] sl_a [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  scf_cordic_rotator uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_angle(in_angle),
    .out_valid(out_valid), .out_cos(out_cos), .out_sin(out_sin)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Arithmetic model of R3/R4/R5/R6 with seven stages (R8)
  task automatic model(input logic [15:0] a, output logic signed [15:0] c, output logic signed [15:0] s);
    logic [15:0] r;
    logic signed [15:0] x, y, xn, yn;
    int sh;
    r = a; x = 16'sd16384; y = 16'sd0;
    for (int st = 0; st < 7; st++) begin
      if (r >= 16'd16384) begin
        sh = 2; r = r - 16'd16384;
      end else if (r != 0) begin
        int p;
        p = 15;
        while (!r[p]) p--;
        sh = 16 - p; r[p] = 1'b0;
      end else sh = 0;
      if (sh != 0) begin
        xn = x - (x >>> (2*sh+1)) - (y >>> sh) + (y >>> (3*sh+3));
        yn = y - (y >>> (2*sh+1)) + (x >>> sh) - (x >>> (3*sh+3));
        x = xn; y = yn;
      end
    end
    c = x; s = y;
  endtask

  task automatic run_one(input logic [15:0] a, input int ec, input int es, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_angle = a;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2", int'(out_valid), 1);
    chk(out_cos == 16'(ec), req, int'(out_cos), ec);
    chk(out_sin == 16'(es), req, int'(out_sin), es);
  endtask

  task automatic step(input logic v, input logic [15:0] a);
    logic signed [15:0] ec, es;
    real rc, rs, dc, ds;
    int k;
    @(negedge clk);
    k = (cyc + 1) % 8;
    chk(out_valid == sl_v[k], "R2", int'(out_valid), int'(sl_v[k]));
    if (sl_v[k]) begin
      model(sl_a[k], ec, es);
      chk(out_cos == ec, "R5 cos", int'(out_cos), int'(ec));
      chk(out_sin == es, "R5 sin", int'(out_sin), int'(es));
      rc = $cos(real'(sl_a[k]) / 65536.0) * 16384.0;
      rs = $sin(real'(sl_a[k]) / 65536.0) * 16384.0;
      dc = real'(out_cos) - rc; if (dc < 0) dc = -dc;
      ds = real'(out_sin) - rs; if (ds < 0) ds = -ds;
      chk(dc <= 328.0 && ds <= 328.0, "R9", int'(out_cos), int'(rc));
    end
    in_valid = v; in_angle = a;
    sl_v[cyc % 8] = v; sl_a[cyc % 8] = a;
    cyc++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin sl_v[i] = 1'b0; sl_a[i] = '0; end
    in_valid = 1'b1; in_angle = 16'd100;
    repeat (9) @(negedge clk);
    // R1: reset holds output invalid despite valid input
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);

    run_one(16'd0, 16384, 0, "R6");
    run_one(16'd16384, 15872, 4064, "R7");
    run_one(16'd8192, 16256, 2044, "R7");
    run_one(16'd49152, 11966, 11191, "R8");
    run_one(16'd1, 16384, 0, "R4");
    repeat (8) @(negedge clk);

    // R2/R4/R5/R8/R9: streamed sweep with bubbles, plus edge angles
    step(1'b1, 16'd16383);
    step(1'b1, 16'd16385);
    step(1'b1, 16'd32767);
    step(1'b1, 16'd49151);
    step(1'b0, 16'd0);
    step(1'b1, 16'd51472);
    step(1'b1, 16'd127);
    for (int a = 0; a <= 51472; a += 7) begin
      step(1'b1, 16'(a));
      if (a % 5 == 0) step(1'b0, 16'(a));
    end
    for (int i = 0; i < 8; i++) step(1'b0, 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule